// File: doc/BRIEF.md
# Compact-ISA Branch Target Unit

This block resolves the control-flow instructions of a 16-bit compressed instruction set. Each cycle it may be handed one raw instruction together with the pipeline PC (the instruction's address plus 4), the current link register, a register operand for the exchange form and the four condition flags. One clock later it reports whether the pipeline must be flushed, the new PC, whether the link register is to be written and with what value, and whether an instruction-state change accompanies the branch.

Four branch families are handled. The first is a conditional branch with an 8-bit offset. The second is an unconditional branch with an 11-bit offset. The third is a long call split over two halfwords that carry the partial target in the link register. The fourth is a register-indirect branch that can switch between the compressed and the 32-bit instruction state. The register index for the exchange operand is decoded combinationally, so that a register file read port can supply the operand in the same cycle. Fetch and register storage sit outside the block.

Top module: `bt_branch_unit`

## Requirements
- R1: While `rst_n` is low, `flush`, `lr_we` and `xchg` are 0, and the same holds in the first cycle after reset.
- R2: An instruction with bits [15:12] = 4'b1101 and a passing condition in bits [11:8] raises `flush` one cycle after `insn_valid`. `pc_out` is then `pc_in` plus bits [7:0] sign-extended and multiplied by 2.
- R3: A conditional branch whose condition fails raises none of `flush`, `lr_we` or `xchg`.
- R4: With `flags_in` = {N,Z,C,V} (N at bit 3), condition codes 0 to 13 pass on: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R5: Condition codes 14 and 15 in a 4'b1101 instruction never branch and never write the link register.
- R6: Bits [15:11] = 5'b11100 always flush, with `pc_out` equal to `pc_in` plus bits [10:0] sign-extended and multiplied by 2.
- R7: Bits [15:11] = 5'b11110 write the link register with `pc_in` plus bits [10:0] sign-extended and multiplied by 4096, without a flush.
- R8: Bits [15:11] = 5'b11111 flush to (`lr_in` with bit 0 cleared) plus bits [10:0] zero-extended and multiplied by 2. In the same cycle they write the link register with (`pc_in` - 2) with bit 0 set.
- R9: An exchange is bits [15:7] = 9'b010001110 with bits [2:0] = 0. Any other value of those bits is no branch. `xreg_idx` always equals {bit 6, bits [5:3]}, combinationally.
- R10: An exchange raises `flush` and `xchg`, with `xchg_compact` = `xop_in[0]`. `pc_out` is `xop_in` with bit 0 cleared when `xop_in[0]` is 1, and with bits [1:0] cleared when `xop_in[0]` is 0.
- R11: A cycle without `insn_valid`, or with an instruction outside the encodings above, gives no `flush`, `lr_we` or `xchg` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 16 | Raw instruction |
| pc_in | input | 32 | Instruction address plus 4 |
| lr_in | input | 32 | Current link register |
| xop_in | input | 32 | Exchange register operand |
| flags_in | input | 4 | Condition flags {N,Z,C,V} |
| xreg_idx | output | 4 | Register index of the exchange operand |
| flush | output | 1 | Branch taken, pipeline flush |
| pc_out | output | 32 | New PC, valid with flush |
| lr_we | output | 1 | Link register write enable |
| lr_out | output | 32 | Link register write value |
| xchg | output | 1 | Exchange branch taken |
| xchg_compact | output | 1 | New state is compressed, valid with xchg |

## Verification
The second half of the long call is the one instruction where a flush and a link-register write fall in the same cycle. The bench provokes it by issuing the two halves back to back and feeding the first half's link value back as `lr_in` of the second. In that cycle it compares both the branch target and the new link value against its own model. It also issues the second half on its own with arbitrary link values, and it runs random instruction streams where both halves appear in any order.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned INSN_W = 16;
  localparam int unsigned COND_W = 4;

  typedef enum logic [2:0] {
    BK_NONE    = 3'd0,
    BK_COND    = 3'd1,
    BK_UNCOND  = 3'd2,
    BK_LONG_HI = 3'd3,
    BK_LONG_LO = 3'd4,
    BK_EXCH    = 3'd5
  } bkind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output bkind_e            kind,
  output logic [COND_W-1:0] cond,
  output logic [3:0]        xreg_idx
);
  always_comb begin
    kind     = BK_NONE;
    cond     = insn[11:8];
    xreg_idx = {insn[6], insn[5:3]};
    if (insn[15:12] == 4'b1101) begin
      if (insn[11:9] != 3'b111) kind = BK_COND;
    end else if (insn[15:11] == 5'b11100) begin
      kind = BK_UNCOND;
    end else if (insn[15:11] == 5'b11110) begin
      kind = BK_LONG_HI;
    end else if (insn[15:11] == 5'b11111) begin
      kind = BK_LONG_LO;
    end else if (insn[15:7] == 9'b010001110 && insn[2:0] == 3'b000) begin
      kind = BK_EXCH;
    end
  end
endmodule

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
  import bt_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              pass
);
  localparam int unsigned NCODES = 1 << COND_W;

  function automatic logic code_pass(input int code, input flags_t f);
    case (code)
      0:  return f.z;
      1:  return !f.z;
      2:  return f.c;
      3:  return !f.c;
      4:  return f.n;
      5:  return !f.n;
      6:  return f.v;
      7:  return !f.v;
      8:  return f.c && !f.z;
      9:  return !f.c || f.z;
      10: return f.n == f.v;
      11: return f.n != f.v;
      12: return !f.z && (f.n == f.v);
      13: return f.z || (f.n != f.v);
      default: return 1'b0;
    endcase
  endfunction

  logic [NCODES-1:0] pass_vec;

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    if (g < 14) begin : g_valid
      assign pass_vec[g] = code_pass(g, flags);
    end else begin : g_resv
      assign pass_vec[g] = 1'b0;
    end
  end

  assign pass = pass_vec[cond];
endmodule

// File: rtl/bt_target.sv
module bt_target
  import bt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  bkind_e        kind,
  input  logic [10:0]   offs,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] xop,
  output logic [AW-1:0] tgt,
  output logic [AW-1:0] lr_val,
  output logic          compact
);
  localparam int unsigned OFF_W  = 11;
  localparam int unsigned SH8_W  = 8;
  localparam int unsigned HI_SH  = 12;

  logic [AW-1:0] off8_sx, off11_sx, off11_hi, off11_lo, pc_m2;

  always_comb begin
    off8_sx  = {{(AW-SH8_W-1){offs[SH8_W-1]}}, offs[SH8_W-1:0], 1'b0};
    off11_sx = {{(AW-OFF_W-1){offs[OFF_W-1]}}, offs, 1'b0};
    off11_hi = {{(AW-OFF_W-HI_SH){offs[OFF_W-1]}}, offs, {HI_SH{1'b0}}};
    off11_lo = {{(AW-OFF_W-1){1'b0}}, offs, 1'b0};
    pc_m2    = pc - AW'(2);
    tgt      = '0;
    lr_val   = '0;
    compact  = 1'b0;
    case (kind)
      BK_COND:    tgt = pc + off8_sx;
      BK_UNCOND:  tgt = pc + off11_sx;
      BK_LONG_HI: lr_val = pc + off11_hi;
      BK_LONG_LO: begin
        tgt    = (lr & ~AW'(1)) + off11_lo;
        lr_val = pc_m2 | AW'(1);
      end
      BK_EXCH: begin
        compact = xop[0];
        tgt     = xop[0] ? (xop & ~AW'(1)) : (xop & ~AW'(3));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bt_branch_unit.sv
module bt_branch_unit
  import bt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     lr_in,
  input  logic [AW-1:0]     xop_in,
  input  logic [3:0]        flags_in,
  output logic [3:0]        xreg_idx,
  output logic              flush,
  output logic [AW-1:0]     pc_out,
  output logic              lr_we,
  output logic [AW-1:0]     lr_out,
  output logic              xchg,
  output logic              xchg_compact
);
  bkind_e            kind;
  logic [COND_W-1:0] cond;
  logic              cond_ok;
  logic [AW-1:0]     tgt, lr_val;
  logic              compact;

  bt_decode u_dec (
    .insn     (insn),
    .kind     (kind),
    .cond     (cond),
    .xreg_idx (xreg_idx)
  );

  bt_cond_eval u_cond (
    .cond  (cond),
    .flags (flags_t'(flags_in)),
    .pass  (cond_ok)
  );

  bt_target #(.AW(AW)) u_tgt (
    .kind    (kind),
    .offs    (insn[10:0]),
    .pc      (pc_in),
    .lr      (lr_in),
    .xop     (xop_in),
    .tgt     (tgt),
    .lr_val  (lr_val),
    .compact (compact)
  );

  logic take_d, lrw_d, xc_d;

  always_comb begin
    take_d = 1'b0;
    lrw_d  = 1'b0;
    xc_d   = 1'b0;
    if (insn_valid) begin
      case (kind)
        BK_COND:    take_d = cond_ok;
        BK_UNCOND:  take_d = 1'b1;
        BK_LONG_HI: lrw_d  = 1'b1;
        BK_LONG_LO: begin
          take_d = 1'b1;
          lrw_d  = 1'b1;
        end
        BK_EXCH: begin
          take_d = 1'b1;
          xc_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush <= 1'b0;
      lr_we <= 1'b0;
      xchg  <= 1'b0;
    end else begin
      flush <= take_d;
      lr_we <= lrw_d;
      xchg  <= xc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out       <= '0;
      lr_out       <= '0;
      xchg_compact <= 1'b0;
    end else begin
      if (take_d) pc_out       <= tgt;
      if (lrw_d)  lr_out       <= lr_val;
      if (xc_d)   xchg_compact <= compact;
    end
  end
endmodule

// File: rtl/bt_branch_unit_chk.sv
module bt_branch_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_valid,
  input logic [15:0]   insn,
  input logic          flush,
  input logic [AW-1:0] pc_out,
  input logic          lr_we,
  input logic [AW-1:0] lr_out,
  input logic          xchg,
  input logic          xchg_compact
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(insn_valid) |-> (!flush && !lr_we && !xchg));

  // R8
  long_lo_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lr_we) |-> lr_out[0]);

  // R7
  long_hi_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_we && !flush) |-> !xchg);

  // R10
  exch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg |-> (flush && (xchg_compact ? !pc_out[0] : (pc_out[1:0] == 2'b00))));

  // R5
  cond_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(insn_valid && insn[15:12] == 4'hD && insn[11:9] == 3'b111) |-> (!flush && !lr_we));

  // R3
  cond_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(insn_valid && insn[15:12] == 4'hD) |-> (!lr_we && !xchg));

  // R6
  uncond_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(insn_valid && insn[15:11] == 5'b11100) |-> (flush && !lr_we && !xchg));
endmodule

bind bt_branch_unit bt_branch_unit_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_valid   (insn_valid),
  .insn         (insn),
  .flush        (flush),
  .pc_out       (pc_out),
  .lr_we        (lr_we),
  .lr_out       (lr_out),
  .xchg         (xchg),
  .xchg_compact (xchg_compact)
);

// File: tb/tb_bt_branch_unit.sv
module tb_bt_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [15:0] insn;
  logic [31:0] pc_in, lr_in, xop_in;
  logic [3:0]  flags_in;
  logic [3:0]  xreg_idx;
  logic        flush, lr_we, xchg, xchg_compact;
  logic [31:0] pc_out, lr_out;

  always #2 clk = ~clk;

  bt_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .pc_in(pc_in), .lr_in(lr_in), .xop_in(xop_in), .flags_in(flags_in),
    .xreg_idx(xreg_idx), .flush(flush), .pc_out(pc_out), .lr_we(lr_we),
    .lr_out(lr_out), .xchg(xchg), .xchg_compact(xchg_compact)
  );

  typedef struct {
    bit        fl;
    bit        lw;
    bit        xc;
    bit        cmp;
    bit [31:0] pc;
    bit [31:0] lr;
    string     tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic bit flag_test(bit [3:0] c, bit [3:0] f);
    bit n, z, cy, v, base;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: return 1'b0;
    endcase
    return c[0] ? ~base : base;
  endfunction

  function automatic exp_t model(bit v, bit [15:0] i, bit [31:0] pc, bit [31:0] lr,
                                 bit [31:0] op, bit [3:0] f);
    exp_t e;
    int   off;
    e.fl = 0; e.lw = 0; e.xc = 0; e.cmp = 0; e.pc = 0; e.lr = 0; e.tag = "R11";
    if (!v) return e;
    if (i[15:12] == 4'd13) begin
      if (i[11:8] >= 4'd14) e.tag = "R5";
      else if (flag_test(i[11:8], f)) begin
        off = $signed(i[7:0]);
        e.fl = 1; e.pc = pc + 32'(2 * off); e.tag = "R2";
      end else e.tag = "R3";
    end else if (i[15:11] == 5'b11100) begin
      off = $signed(i[10:0]);
      e.fl = 1; e.pc = pc + 32'(2 * off); e.tag = "R6";
    end else if (i[15:11] == 5'b11110) begin
      off = $signed(i[10:0]);
      e.lw = 1; e.lr = pc + 32'(4096 * off); e.tag = "R7";
    end else if (i[15:11] == 5'b11111) begin
      e.fl = 1; e.lw = 1;
      e.pc = (lr & 32'hFFFF_FFFE) + 32'(2 * int'(i[10:0]));
      e.lr = (pc - 32'd2) | 32'd1; e.tag = "R8";
    end else if (i[15:7] == 9'b010001110 && i[2:0] == 3'd0) begin
      e.fl = 1; e.xc = 1; e.cmp = op[0];
      e.pc = op[0] ? (op & 32'hFFFF_FFFE) : (op & 32'hFFFF_FFFC);
      e.tag = "R10";
    end else if (i[15:10] == 6'b010001) e.tag = "R9";
    return e;
  endfunction

  task automatic chk_bit(string tag, string what, bit act, bit expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  task automatic chk_word(string tag, string what, logic [31:0] act, bit [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, expv);
    end
  endtask

  task automatic compare_front();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk_bit(e.tag, "flush", flush, e.fl);
    chk_bit(e.tag, "lr_we", lr_we, e.lw);
    chk_bit(e.tag, "xchg", xchg, e.xc);
    if (e.fl) chk_word(e.tag, "pc_out", pc_out, e.pc);
    if (e.lw) chk_word(e.tag, "lr_out", lr_out, e.lr);
    if (e.xc) chk_bit(e.tag, "xchg_compact", xchg_compact, e.cmp);
  endtask

  task automatic step(bit v, bit [15:0] i, bit [31:0] pc, bit [31:0] lr,
                      bit [31:0] op, bit [3:0] f, string tag_ovr);
    exp_t e;
    @(negedge clk);
    compare_front();
    insn_valid = v; insn = i; pc_in = pc; lr_in = lr; xop_in = op; flags_in = f;
    e = model(v, i, pc, lr, op, f);
    if (tag_ovr != "") e.tag = tag_ovr;
    exp_q.push_back(e);
    #1;
    // R9: combinational register index
    chk_word("R9", "xreg_idx", {28'd0, xreg_idx}, {28'd0, i[6], i[5:3]});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] lr_chain;
    exp_t      eh;
    rst_n = 0; insn_valid = 0; insn = 0; pc_in = 0; lr_in = 0; xop_in = 0; flags_in = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_bit("R1", "flush", flush, 0);
    chk_bit("R1", "lr_we", lr_we, 0);
    chk_bit("R1", "xchg", xchg, 0);
    rst_n = 1;
    step(0, 16'hE000, 32'h100, 0, 0, 0, "R1");

    // R4: every code against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        step(1, {4'hD, 4'(c), 8'(c * 17 + f * 5)}, 32'h0000_2000 + 32'(f * 16), 0, 0, 4'(f),
             (c >= 14) ? "R5" : "R4");

    // R2: offset extremes
    step(1, 16'hD07F, 32'h1000, 0, 0, 4'b0100, "R2");
    step(1, 16'hD080, 32'h1000, 0, 0, 4'b0100, "R2");
    step(1, 16'hD0FF, 32'h0000_0002, 0, 0, 4'b0100, "R2");

    // R6: unconditional offset extremes
    step(1, 16'hE3FF, 32'h8000, 0, 0, 0, "R6");
    step(1, 16'hE400, 32'h8000, 0, 0, 0, "R6");
    step(1, 16'hE000, 32'h8000, 0, 0, 0, "R6");

    // R7 then R8: chained halves, link value fed back
    for (int k = 0; k < 6; k++) begin
      bit [15:0] hi, lo;
      bit [31:0] p;
      hi = {5'b11110, 11'((k * 301) ^ (k[0] ? 11'h400 : 11'h000))};
      lo = {5'b11111, 11'(k * 517 + 3)};
      p  = 32'h0800_0000 + 32'(k * 64);
      eh = model(1, hi, p, 0, 0, 0);
      lr_chain = eh.lr;
      step(1, hi, p, 32'hDEAD_BEEF, 0, 0, "R7");
      step(1, lo, p + 32'd2, lr_chain, 0, 0, "R8");
    end
    step(1, 16'hFFFF, 32'h0000_0010, 32'hFFFF_FFFF, 0, 0, "R8");

    // R10: exchange into both states, low and high registers
    step(1, 16'h4770, 32'h300, 0, 32'h0000_1235, 0, "R10");
    step(1, 16'h4738, 32'h300, 0, 32'h0000_4567, 0, "R10");
    step(1, 16'h4700, 32'h300, 0, 32'hFFFF_FFFE, 0, "R10");
    // R9: set bit 7 or a nonzero low field gives no branch
    step(1, 16'h47F0, 32'h300, 0, 32'h0000_1235, 0, "R9");
    step(1, 16'h4771, 32'h300, 0, 32'h0000_1235, 0, "R9");

    // R11: idle and non-branch instructions
    step(0, 16'hF800, 32'h400, 32'h1, 0, 0, "R11");
    step(1, 16'h1C08, 32'h400, 32'h1, 0, 0, "R11");
    step(1, 16'hDF10, 32'h400, 0, 0, 4'hF, "R5");

    // random stream, biased toward branch encodings
    for (int n = 0; n < 3000; n++) begin
      bit [15:0] r;
      r = 16'($urandom);
      case ($urandom % 6)
        0: r[15:12] = 4'hD;
        1: r[15:11] = 5'b11100;
        2: r[15:11] = 5'b11110;
        3: r[15:11] = 5'b11111;
        4: begin r[15:7] = 9'b010001110; if ($urandom % 4 != 0) r[2:0] = 0; end
        default: ;
      endcase
      step(($urandom % 8) != 0, r, $urandom, $urandom, $urandom, 4'($urandom), "");
    end

    step(0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    compare_front();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule